// File: doc/BRIEF.md
# Two-Level Grouped Interrupt Aggregator

This block merges the interrupt events of a peripheral into a single interrupt line. Each event arrives as a one-cycle pulse and sets a sticky status bit. The status bits fall into three groups: control-endpoint sources (group 0), data-FIFO sources (group 1) and device-state sources (group 2). Each group has a per-source disable mask and produces one summary bit. A group disable mask decides which summaries may raise the device request.

The device request sits in a three-bit top-level status register, next to sticky host and OTG request bits. A top-level mask disables individual top-level bits, and one more bit of that mask selects the polarity of the output line.

Software reaches every register through a flat word-addressed port. Writes take effect on the clock edge. Reads are combinational.

Register addresses (on `reg_addr_i`):
- 0x0: top status (write one to clear).
- 0x1: top mask.
- 0x2: group disable.
- 0x3: group summary (read-only).
- 0x4, 0x5, 0x6: status of groups 0, 1 and 2 (write one to clear).
- 0x8, 0x9, 0xA: source disable masks of groups 0, 1 and 2.

Every other address reads as zero.

Top module: `irq_rollup`

## Requirements
- R1: After a synchronous reset, every status and disable register reads zero. The top mask reads 0x8, which selects an active-high output. `irq_o` is low.
- R2: A one-cycle pulse on an event input sets the matching source status bit at the next clock edge. The bit stays set until it is cleared.
  - Group 0 bits 0 to 5 are: setup, IN packet, OUT packet, command end, command error, command abort.
  - Group 2 bits 0 to 10 are: bus reset, suspend, resume, isochronous error, isochronous abort, zero-length sent, zero-length received, DMA done, DMA error, idle, wakeup.
- R3: Group 1 serves N_FIFO FIFOs. For FIFO n, the OUT source is bit 2n, the short-packet source is bit 2n+1 and the IN source is bit 16+n. All other bits of group 1 status and mask read zero and cannot be set. With N_FIFO=4 the valid mask is 0xF00FF.
- R4: Writing ones to a source status register clears those bits, and zeros leave bits unchanged. If an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R5: Group summary bit g (register 0x3, bit g) is the OR of the status bits of group g whose disable bit is zero. Writes to the summary register have no effect.
- R6: Setting group disable bit g keeps group g from setting the device request. The summary bit still reports that group.
- R7: Top status bit 2 is set by a host request pulse and bit 1 by an OTG request pulse. Bit 0 is set in every cycle in which any enabled group summary is high. The bits are cleared by writing ones, and a set in the same cycle wins over the clear.
- R8: Top mask bits 2 to 0 disable the matching top status bit from reaching `irq_o`. The raw interrupt is the OR of the enabled top status bits.
- R9: Top mask bit 3 selects polarity. When it is 1, `irq_o` equals the raw interrupt. When it is 0, `irq_o` is the inverse of the raw interrupt.
- R10: Reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_ctl_i | input | 6 | Group 0 event pulses |
| evt_fifo_i | input | 16+N_FIFO | Group 1 event pulses |
| evt_dev_i | input | 11 | Group 2 event pulses |
| host_req_i | input | 1 | Host request pulse |
| otg_req_i | input | 1 | OTG request pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 16+N_FIFO | Write data |
| reg_rdata_o | output | 16+N_FIFO | Read data (combinational) |
| irq_o | output | 1 | Interrupt line, polarity set by top mask bit 3 |

## Verification
The bench builds the block with the default N_FIFO=4. This gives a 20-bit data path, so the gaps in group 1 between bits 7 and 16 are exercised. Driving all 20 group 1 event lines at once shows that only the 0xF00FF bits can latch. The same default lets the bench set one FIFO source enable against a fully disabled group and watch the summary react.

// File: rtl/irq_rollup_pkg.sv
package irq_rollup_pkg;

    localparam int NGRP   = 3;
    localparam int G0_W   = 6;
    localparam int G2_W   = 11;
    localparam int ADDR_W = 4;
    localparam int IN_OFS = 16;

    typedef enum logic [ADDR_W-1:0] {
        A_TOP_STAT = 4'h0,
        A_TOP_MASK = 4'h1,
        A_GRP_DIS  = 4'h2,
        A_GRP_SUM  = 4'h3,
        A_G0_STAT  = 4'h4,
        A_G1_STAT  = 4'h5,
        A_G2_STAT  = 4'h6,
        A_G0_MASK  = 4'h8,
        A_G1_MASK  = 4'h9,
        A_G2_MASK  = 4'hA
    } reg_addr_e;

    typedef struct packed {
        logic       act_high;
        logic [2:0] dis;
    } top_mask_t;

    localparam top_mask_t TOP_MASK_RST = '{act_high: 1'b1, dis: 3'b000};

    // Valid-bit pattern of the FIFO group: OUT/short-packet pairs low, IN bits from 16.
    function automatic logic [31:0] fifo_grp_valid(int nfifo);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < nfifo; i++) begin
            m[2*i]        = 1'b1;
            m[2*i+1]      = 1'b1;
            m[IN_OFS + i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_src_group.sv
module irq_src_group #(
    parameter int           W     = 6,
    parameter logic [W-1:0] VALID = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  logic         stat_clr_we,
    input  logic         mask_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] stat,
    output logic [W-1:0] mask,
    output logic         summary
);

    logic [W-1:0] clr_bits;
    logic [W-1:0] stat_d;

    always_comb begin
        clr_bits = stat_clr_we ? wdata : '0;
        stat_d   = ((stat & ~clr_bits) | evt) & VALID;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
            mask <= '0;
        end else begin
            stat <= stat_d;
            if (mask_we) mask <= wdata & VALID;
        end
    end

    assign summary = |(stat & ~mask);

endmodule

// File: rtl/irq_top_ctrl.sv
module irq_top_ctrl
    import irq_rollup_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      host_req,
    input  logic      otg_req,
    input  logic      dev_req,
    input  logic      stat_clr_we,
    input  logic      mask_we,
    input  logic [3:0] wdata,
    output logic [2:0] top_stat,
    output top_mask_t top_mask,
    output logic      irq_o
);

    logic [2:0] set_bits;
    logic [2:0] clr_bits;
    logic       raw_irq;

    always_comb begin
        set_bits = {host_req, otg_req, dev_req};
        clr_bits = stat_clr_we ? wdata[2:0] : 3'b000;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            top_stat <= '0;
            top_mask <= TOP_MASK_RST;
        end else begin
            top_stat <= (top_stat & ~clr_bits) | set_bits;
            if (mask_we) top_mask <= top_mask_t'(wdata);
        end
    end

    assign raw_irq = |(top_stat & ~top_mask.dis);
    assign irq_o   = top_mask.act_high ? raw_irq : ~raw_irq;

endmodule

// File: rtl/irq_rollup.sv
module irq_rollup
    import irq_rollup_pkg::*;
#(
    parameter  int N_FIFO = 4,
    localparam int G1_W   = IN_OFS + N_FIFO,
    localparam int DW     = G1_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [G0_W-1:0]   evt_ctl_i,
    input  logic [G1_W-1:0]   evt_fifo_i,
    input  logic [G2_W-1:0]   evt_dev_i,
    input  logic              host_req_i,
    input  logic              otg_req_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DW-1:0]     reg_wdata_i,
    output logic [DW-1:0]     reg_rdata_o,
    output logic              irq_o
);

    localparam logic [31:0]     G1_VALID32 = fifo_grp_valid(N_FIFO);
    localparam logic [G1_W-1:0] G1_VALID   = G1_VALID32[G1_W-1:0];

    logic [G0_W-1:0] g0_stat, g0_mask;
    logic [G1_W-1:0] g1_stat, g1_mask;
    logic [G2_W-1:0] g2_stat, g2_mask;
    logic [NGRP-1:0] gsum;
    logic [NGRP-1:0] grp_dis_q;
    logic            dev_req;
    logic [2:0]      top_stat;
    top_mask_t       top_mask;

    function automatic logic wsel(logic we, logic [ADDR_W-1:0] a, reg_addr_e t);
        return we && (a == t);
    endfunction

    irq_src_group #(.W(G0_W), .VALID('1)) u_grp0 (
        .clk(clk), .rst(rst), .evt(evt_ctl_i),
        .stat_clr_we(wsel(reg_we_i, reg_addr_i, A_G0_STAT)),
        .mask_we(wsel(reg_we_i, reg_addr_i, A_G0_MASK)),
        .wdata(reg_wdata_i[G0_W-1:0]),
        .stat(g0_stat), .mask(g0_mask), .summary(gsum[0])
    );

    irq_src_group #(.W(G1_W), .VALID(G1_VALID)) u_grp1 (
        .clk(clk), .rst(rst), .evt(evt_fifo_i),
        .stat_clr_we(wsel(reg_we_i, reg_addr_i, A_G1_STAT)),
        .mask_we(wsel(reg_we_i, reg_addr_i, A_G1_MASK)),
        .wdata(reg_wdata_i[G1_W-1:0]),
        .stat(g1_stat), .mask(g1_mask), .summary(gsum[1])
    );

    irq_src_group #(.W(G2_W), .VALID('1)) u_grp2 (
        .clk(clk), .rst(rst), .evt(evt_dev_i),
        .stat_clr_we(wsel(reg_we_i, reg_addr_i, A_G2_STAT)),
        .mask_we(wsel(reg_we_i, reg_addr_i, A_G2_MASK)),
        .wdata(reg_wdata_i[G2_W-1:0]),
        .stat(g2_stat), .mask(g2_mask), .summary(gsum[2])
    );

    always_ff @(posedge clk) begin
        if (rst)                                        grp_dis_q <= '0;
        else if (wsel(reg_we_i, reg_addr_i, A_GRP_DIS)) grp_dis_q <= reg_wdata_i[NGRP-1:0];
    end

    assign dev_req = |(gsum & ~grp_dis_q);

    irq_top_ctrl u_top (
        .clk(clk), .rst(rst),
        .host_req(host_req_i), .otg_req(otg_req_i), .dev_req(dev_req),
        .stat_clr_we(wsel(reg_we_i, reg_addr_i, A_TOP_STAT)),
        .mask_we(wsel(reg_we_i, reg_addr_i, A_TOP_MASK)),
        .wdata(reg_wdata_i[3:0]),
        .top_stat(top_stat), .top_mask(top_mask), .irq_o(irq_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            A_TOP_STAT: reg_rdata_o[2:0]      = top_stat;
            A_TOP_MASK: reg_rdata_o[3:0]      = top_mask;
            A_GRP_DIS:  reg_rdata_o[NGRP-1:0] = grp_dis_q;
            A_GRP_SUM:  reg_rdata_o[NGRP-1:0] = gsum;
            A_G0_STAT:  reg_rdata_o[G0_W-1:0] = g0_stat;
            A_G1_STAT:  reg_rdata_o[G1_W-1:0] = g1_stat;
            A_G2_STAT:  reg_rdata_o[G2_W-1:0] = g2_stat;
            A_G0_MASK:  reg_rdata_o[G0_W-1:0] = g0_mask;
            A_G1_MASK:  reg_rdata_o[G1_W-1:0] = g1_mask;
            A_G2_MASK:  reg_rdata_o[G2_W-1:0] = g2_mask;
            default:    reg_rdata_o           = '0;
        endcase
    end

endmodule

// File: rtl/irq_rollup_chk.sv
module irq_rollup_chk
    import irq_rollup_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [G0_W-1:0]   evt_ctl_i,
    input logic              host_req_i,
    input logic              otg_req_i,
    input logic              reg_we_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [G0_W-1:0]   g0_stat,
    input logic [2:0]        top_stat,
    input top_mask_t         top_mask,
    input logic              irq_o
);

    // R1: reset leaves clean status, active-high polarity, idle line
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (top_stat == 3'b000 && top_mask == TOP_MASK_RST && !irq_o));

    // R2: a pulse latches its bit on the next edge
    a_r2_event_latches: assert property (@(posedge clk) disable iff (rst)
        (evt_ctl_i != '0) |=> ((g0_stat & $past(evt_ctl_i)) == $past(evt_ctl_i)));

    // R4: without a clear write, status bits never drop
    a_r4_sticky_hold: assert property (@(posedge clk) disable iff (rst)
        !(reg_we_i && reg_addr_i == A_G0_STAT) |=> ((g0_stat & $past(g0_stat)) == $past(g0_stat)));

    // R7: host and OTG pulses latch in the top register
    a_r7_host_sets: assert property (@(posedge clk) disable iff (rst)
        host_req_i |=> top_stat[2]);

    a_r7_otg_sets: assert property (@(posedge clk) disable iff (rst)
        otg_req_i |=> top_stat[1]);

    // R8: all top bits disabled gives the inactive level of the chosen polarity
    a_r8_all_disabled: assert property (@(posedge clk) disable iff (rst)
        (top_mask.dis == 3'b111) |-> (irq_o == !top_mask.act_high));

endmodule

bind irq_rollup irq_rollup_chk u_chk (
    .clk(clk), .rst(rst), .evt_ctl_i(evt_ctl_i),
    .host_req_i(host_req_i), .otg_req_i(otg_req_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .g0_stat(g0_stat), .top_stat(top_stat), .top_mask(top_mask), .irq_o(irq_o)
);

// File: tb/test_irq_rollup.sv
module test_irq_rollup;

    localparam int CLK_PERIOD = 10;
    localparam int N_FIFO     = 4;
    localparam int DW         = 16 + N_FIFO;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [5:0]    evt_ctl = '0;
    logic [DW-1:0] evt_fifo = '0;
    logic [10:0]   evt_dev = '0;
    logic          host_req = 1'b0;
    logic          otg_req = 1'b0;
    logic          reg_we = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_rollup #(.N_FIFO(N_FIFO)) i_irq_rollup (
        .clk(clk), .rst(rst),
        .evt_ctl_i(evt_ctl), .evt_fifo_i(evt_fifo), .evt_dev_i(evt_dev),
        .host_req_i(host_req), .otg_req_i(otg_req),
        .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .irq_o(irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Write with optional simultaneous events on the same edge
    task automatic wr_ev(logic [3:0] a, logic [DW-1:0] d, logic [5:0] ctl, logic h);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d; evt_ctl = ctl; host_req = h;
        @(negedge clk);
        reg_we = 1'b0; evt_ctl = '0; host_req = 1'b0;
    endtask

    task automatic wr(logic [3:0] a, logic [DW-1:0] d);
        wr_ev(a, d, 6'd0, 1'b0);
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = 32'(reg_rdata);
    endtask

    task automatic pulse(logic [5:0] c, logic [DW-1:0] f, logic [10:0] d, logic h, logic o);
        @(negedge clk);
        evt_ctl = c; evt_fifo = f; evt_dev = d; host_req = h; otg_req = o;
        @(negedge clk);
        evt_ctl = '0; evt_fifo = '0; evt_dev = '0; host_req = 1'b0; otg_req = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), v);
            chk(a == 1 ? "R1 top mask" : "R1/R10 reg", v, a == 1 ? 32'h8 : 32'h0);
        end
        chk("R1 irq", 32'(irq), 32'h0);
    endtask

    task automatic t_group0();
        logic [31:0] v;
        pulse(6'b100101, '0, '0, 1'b0, 1'b0);
        rd(4'h4, v); chk("R2 g0 status", v, 32'h25);
        rd(4'h3, v); chk("R5 summary", v, 32'h1);
        tick();
        rd(4'h0, v); chk("R7 device bit", v, 32'h1);
        chk("R8 irq high", 32'(irq), 32'h1);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(4'h4, DW'(32'h01));
        rd(4'h4, v); chk("R4 partial clear", v, 32'h24);
        wr_ev(4'h4, DW'(32'h24), 6'h04, 1'b0);
        rd(4'h4, v); chk("R4 event wins", v, 32'h04);
        wr(4'h4, DW'(32'h04));
        rd(4'h4, v); chk("R4 cleared", v, 32'h0);
        rd(4'h0, v); chk("R7 device sticky", v, 32'h1);
        wr(4'h0, DW'(32'h1));
        rd(4'h0, v); chk("R7 top cleared", v, 32'h0);
        chk("R8 irq low", 32'(irq), 32'h0);
    endtask

    task automatic t_fifo();
        logic [31:0] v;
        pulse('0, '1, '0, 1'b0, 1'b0);
        rd(4'h5, v); chk("R3 g1 valid bits", v, 32'hF00FF);
        wr(4'h9, '1);
        rd(4'h9, v); chk("R3 g1 mask bits", v, 32'hF00FF);
        rd(4'h3, v); chk("R5 group masked", v, 32'h0);
        wr(4'h9, DW'(32'hF00EF));
        rd(4'h3, v); chk("R5 one source on", v, 32'h2);
        wr(4'h5, '1);
        wr(4'h9, '0);
        tick();
        wr(4'h0, DW'(32'h7));
        rd(4'h0, v); chk("R7 top clear", v, 32'h0);
    endtask

    task automatic t_grp();
        logic [31:0] v;
        wr(4'h2, DW'(32'h4));
        pulse('0, '0, 11'h401, 1'b0, 1'b0);
        rd(4'h6, v); chk("R2 g2 status", v, 32'h401);
        rd(4'h3, v); chk("R6 summary kept", v, 32'h4);
        tick(); tick();
        rd(4'h0, v); chk("R6 group blocked", v, 32'h0);
        wr(4'h3, '0);
        rd(4'h3, v); chk("R5 summary read-only", v, 32'h4);
        rd(4'h7, v); chk("R10 unmapped", v, 32'h0);
        wr(4'h2, '0);
        tick();
        rd(4'h0, v); chk("R6 group enabled", v, 32'h1);
        wr(4'h6, '1);
        tick();
        wr(4'h0, DW'(32'h7));
        rd(4'h0, v); chk("R7 cleanup", v, 32'h0);
    endtask

    task automatic t_host();
        logic [31:0] v;
        pulse('0, '0, '0, 1'b1, 1'b0);
        rd(4'h0, v); chk("R7 host bit2", v, 32'h4);
        chk("R8 irq host", 32'(irq), 32'h1);
        wr(4'h1, DW'(32'hC));
        chk("R8 host disabled", 32'(irq), 32'h0);
        pulse('0, '0, '0, 1'b0, 1'b1);
        rd(4'h0, v); chk("R7 otg bit1", v, 32'h6);
        chk("R8 otg enabled", 32'(irq), 32'h1);
        wr(4'h1, DW'(32'h4));
        chk("R9 active low asserted", 32'(irq), 32'h0);
        wr(4'h1, DW'(32'h6));
        chk("R9 active low idle", 32'(irq), 32'h1);
        wr(4'h1, DW'(32'h8));
        wr_ev(4'h0, DW'(32'h6), 6'd0, 1'b1);
        rd(4'h0, v); chk("R7 set wins", v, 32'h4);
        wr(4'h0, DW'(32'h4));
        rd(4'h0, v); chk("R7 all clear", v, 32'h0);
        chk("R9 active high idle", 32'(irq), 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_group0();
        t_w1c();
        t_fifo();
        t_grp();
        t_host();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule